// File: doc/BRIEF.md
# I2C Channel-Select Slave Controller

This block is the digital control core of a bus fan-out device that sits on an I2C bus as a slave. It oversamples SCL and SDA with a fast system clock, detects START, repeated START and STOP, and answers to one 7-bit address. The upper four bits of that address are fixed at `1110`. The lower three bits come from strap inputs. A write transfers one control byte. A read returns the applied channel setting together with the live, inverted state of the downstream interrupt lines. The block's output is a vector of per-channel enables that steers external pass gates.

Two build parameters shape the block. `N_CH` sets 2, 4 or 8 channels. `MUX_MODE` selects switch behaviour (any combination of channels) or multiplexer behaviour (at most one channel, chosen by an enable bit and a select field). Multiplexer builds are limited to 2 or 4 channels. A newly written setting reaches the enables only when the next STOP is seen, so traffic sent after a repeated START still runs on the old channel set. The downstream interrupt inputs are active low. They are combined without latching into one open-drain request output.

Top module: `i2c_chan_select`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `{4'b1110, strap & ADDR_PINS}`; for any other address it never drives SDA and its channel setting is unchanged.
- R2: In a write (address LSB 0), the single byte that follows the address is acknowledged and taken as the new control value; bytes beyond it are not acknowledged.
- R3: A written value moves to `ch_en` only after a STOP; a repeated START does not apply it, and a read before that STOP returns the previous setting.
- R4: In switch mode, `ch_en[i]` equals bit i of the applied control byte, for every i below `N_CH`.
- R5: In multiplexer mode, bit 2 is the enable and bits 1:0 (bit 0 only for two channels) select the channel; with bit 2 at 0 no channel is on, and at most one enable is ever high.
- R6: An active `rst` clears all channel enables, drops any pending write and returns the bus logic to idle.
- R7: `irq_drive_low` is high while any `int_n_i` bit is low and falls again when all of them are high; nothing is latched.
- R8: A read (address LSB 1) returns a byte whose bits 7..4 carry the inverted interrupt inputs of channels 3..0 (1 = request present, bits with no input read 0) and whose low bits carry the applied setting, with unused setting bits at 0; an 8-channel switch returns the full setting byte instead. The same byte repeats while the master acknowledges, and SDA is released after a NACK.
- R9: SDA is driven low only during an acknowledge slot or a read data bit driven as 0, and it is released at every START; there is no SCL output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset (power-on or pin reset) |
| strap | input | 3 | Address strap pins, low three address bits |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| int_n_i | input | min(N_CH,4) | Active-low interrupt request per downstream channel |
| irq_drive_low | output | 1 | 1 pulls the shared interrupt line low |
| ch_en | output | N_CH | Per-channel pass-gate enable |

## Verification
On every cycle, the assertions check the following. The setting register moves only right after a detected STOP. The multiplexer enables stay one-hot or empty. SDA is driven only in acknowledge and read-data states, and it is released after a START. An acknowledge is given only after a matching address. The interrupt output follows a falling request. The bench scenarios show what a property cannot: that the addressed and unaddressed devices share one bus, the full bit-level write and read framing, the deferred application across a repeated START, the exact read-back byte formats of both modes, and random control bytes compared against expected values.

// File: rtl/i2csel_pkg.sv
package i2csel_pkg;
  localparam logic [3:0] ADDR_HI = 4'b1110;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AEND, S_AACK, S_WR, S_WEND,
    S_WACK, S_RD, S_RACK, S_RNEXT, S_WAIT
  } bus_st_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[SYNC-1];
  assign sda_s    = sda_ff[SYNC-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high are bus conditions
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2csel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [6:0] dev_addr,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output logic       wr_pulse,
  output logic [7:0] wr_data
);
  bus_st_t    st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic       rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      wr_pulse <= 1'b0;
    end else begin
      wr_pulse <= 1'b0;
      if (start_ev) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= (st == S_ADDR) ? S_AEND : S_WEND;
          end
          S_AEND: if (scl_fall) begin
            if (sh[7:1] == dev_addr) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              st     <= S_AACK;
            end else begin
              st <= S_WAIT;
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_WEND: if (scl_fall) begin
            sda_oe   <= 1'b1;
            wr_pulse <= 1'b1;
            st       <= S_WACK;
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WAIT;
          end
          S_RD: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
              cnt    <= cnt + 3'd1;
            end
          end
          S_RACK: if (scl_rise) st <= sda_s ? S_WAIT : S_RNEXT;
          S_RNEXT: if (scl_fall) begin
            sh     <= tx_byte;
            sda_oe <= ~tx_byte[7];
            cnt    <= '0;
            st     <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_data = sh;

  a_r9_drive_only_ack_or_read: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == S_AACK || st == S_WACK || st == S_RD));
  a_r9_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe);
  a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && st == S_AACK) |-> ($past(sh[7:1]) == dev_addr));
endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
  parameter int N_CH     = 4,
  parameter bit MUX_MODE = 1'b0
) (
  input  logic [7:0]      wr_byte,
  input  logic [7:0]      cfg,
  output logic [7:0]      cfg_masked,
  output logic [N_CH-1:0] en
);
  localparam logic [7:0] SW_MASK  = 8'((16'd1 << N_CH) - 16'd1);
  localparam logic [7:0] SEL_MASK = (N_CH == 2) ? 8'h01 : 8'h03;
  localparam logic [7:0] CFG_MASK = MUX_MODE ? (SEL_MASK | 8'h04) : SW_MASK;

  assign cfg_masked = wr_byte & CFG_MASK;

  if (MUX_MODE) begin : g_mux
    for (genvar i = 0; i < N_CH; i++) begin : g_en
      assign en[i] = cfg[2] && ((cfg & SEL_MASK) == 8'(i));
    end
  end else begin : g_sw
    for (genvar i = 0; i < N_CH; i++) begin : g_en
      assign en[i] = |(cfg & (8'd1 << i));
    end
  end
endmodule

// File: rtl/i2c_chan_select.sv
module i2c_chan_select
  import i2csel_pkg::*;
#(
  parameter int       N_CH      = 4,
  parameter bit       MUX_MODE  = 1'b0,
  parameter logic [2:0] ADDR_PINS = 3'b111
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [2:0]                      strap,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            sda_oe,
  input  logic [(N_CH > 4 ? 4 : N_CH)-1:0] int_n_i,
  output logic                            irq_drive_low,
  output logic [N_CH-1:0]                 ch_en
);
  localparam int IW = (N_CH > 4) ? 4 : N_CH;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_pulse;
  logic [7:0] wr_data, cfg_new, pend_q, cfg_q, rd_byte;
  logic pend_vld;
  logic [N_CH-1:0] en_dec, ch_en_q;
  logic [IW-1:0] int_ff, int_s;
  logic [3:0] irq_bits;
  logic irq_low_q;
  logic [6:0] dev_addr;

  assign dev_addr = {ADDR_HI, strap & ADDR_PINS};

  i2c_line_sampler #(.SYNC(2)) u_samp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .dev_addr(dev_addr), .tx_byte(rd_byte), .sda_oe(sda_oe),
    .wr_pulse(wr_pulse), .wr_data(wr_data)
  );

  chan_decode #(.N_CH(N_CH), .MUX_MODE(MUX_MODE)) u_dec (
    .wr_byte(wr_data), .cfg(cfg_q), .cfg_masked(cfg_new), .en(en_dec)
  );

  assign irq_bits = 4'(~int_s);
  assign rd_byte  = (N_CH < 8) ? {irq_bits, cfg_q[3:0]} : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      pend_vld  <= 1'b0;
      cfg_q     <= '0;
      ch_en_q   <= '0;
      int_ff    <= '1;
      int_s     <= '1;
      irq_low_q <= 1'b0;
    end else begin
      int_ff    <= int_n_i;
      int_s     <= int_ff;
      irq_low_q <= ~&int_s;
      ch_en_q   <= en_dec;
      if (wr_pulse) begin
        pend_q   <= cfg_new;
        pend_vld <= 1'b1;
      end
      if (stop_ev && pend_vld) begin
        cfg_q    <= pend_q;
        pend_vld <= 1'b0;
      end
    end
  end

  assign ch_en         = ch_en_q;
  assign irq_drive_low = irq_low_q;

  a_r3_cfg_moves_on_stop: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> $past(stop_ev));
  a_r7_irq_follows_request: assert property (@(posedge clk) disable iff (rst)
    $fell(&int_s) |=> irq_drive_low);
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (ch_en_q == '0));

  if (MUX_MODE) begin : g_mux_chk
    a_r5_single_channel: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ch_en_q));
  end
endmodule

// File: tb/sim_i2c_chan_select.sv
`timescale 1ns/1ps
module sim_i2c_chan_select;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'h70;  // switch, strap 000
  localparam logic [6:0] A1 = 7'h75;  // multiplexer, strap 101

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] intn0 = 4'hF, intn1 = 4'hF;
  logic oe0, oe1, irq0, irq1;
  logic [3:0] en0, en1;
  wire sda_bus = sda_m & ~oe0 & ~oe1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] cfg0 = 8'h00, cfg1 = 8'h00;

  always #5 clk = ~clk;

  i2c_chan_select #(.N_CH(4), .MUX_MODE(1'b0)) u0 (
    .clk(clk), .rst(rst), .strap(3'b000), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(oe0), .int_n_i(intn0), .irq_drive_low(irq0), .ch_en(en0));
  i2c_chan_select #(.N_CH(4), .MUX_MODE(1'b1)) u1 (
    .clk(clk), .rst(rst), .strap(3'b101), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(oe1), .int_n_i(intn1), .irq_drive_low(irq1), .ch_en(en1));

  function automatic logic [3:0] sw_en(input logic [7:0] b); return b[3:0]; endfunction
  function automatic logic [3:0] mx_en(input logic [7:0] b);
    return b[2] ? (4'b0001 << b[1:0]) : 4'b0000;
  endfunction
  function automatic logic [7:0] rd_exp(input logic [3:0] intn, input logic [7:0] c);
    return {~intn, c[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i_start;   // also works as repeated START from SCL low
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic i_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(3*Q);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask
  task automatic sbyte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack);
  endtask
  task automatic gbyte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(nack);
  endtask

  task automatic wr_dev(input logic [6:0] a, input logic [7:0] d, output logic aa, output logic ad);
    i_start; sbyte({a, 1'b0}, aa); sbyte(d, ad); i_stop;
  endtask
  task automatic rd_dev(input logic [6:0] a, output logic aa, output logic [7:0] v);
    i_start; sbyte({a, 1'b1}, aa); gbyte(v, 1'b1); i_stop;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic aa, ad, x;
    logic [7:0] v, v2;
    void'($urandom(32'd1234));
    wq(10); rst = 1'b0; wq(10);

    // R6: reset state
    chk(en0 == 4'h0 && en1 == 4'h0, "R6 reset enables", {en0, en1}, 0);
    chk(!oe0 && !oe1, "R9 idle release", {oe0, oe1}, 0);
    chk(!irq0 && !irq1, "R7 idle irq", {irq0, irq1}, 0);

    // R2/R4: switch write, R3 not applied before STOP
    i_start; sbyte({A0, 1'b0}, aa); sbyte(8'h0B, ad);
    chk(aa == 1'b0, "R1 own address ack", aa, 0);
    chk(ad == 1'b0, "R2 data ack", ad, 0);
    wq(12);
    chk(en0 == 4'h0, "R3 held before stop", en0, 0);
    i_stop; wq(12); cfg0 = 8'h0B;
    chk(en0 == sw_en(cfg0), "R4 switch enables", en0, sw_en(cfg0));

    // R1: foreign address ignored, R9 no drive on foreign traffic
    i_start; sbyte({7'h72, 1'b0}, aa); sbyte(8'h00, ad); i_stop; wq(12);
    chk(aa == 1'b1, "R1 foreign nack", aa, 1);
    chk(en0 == sw_en(cfg0) && en1 == 4'h0, "R1 foreign no change", {en0, en1}, {sw_en(cfg0), 4'h0});

    // R2: extra byte after control byte not acknowledged
    i_start; sbyte({A0, 1'b0}, aa); sbyte(8'h03, ad); sbyte(8'h0F, x); i_stop; wq(12);
    cfg0 = 8'h03;
    chk(x == 1'b1, "R2 second byte nack", x, 1);
    chk(en0 == sw_en(cfg0), "R2 first byte used", en0, sw_en(cfg0));

    // R3: write, repeated START, read returns old setting
    i_start; sbyte({A0, 1'b0}, aa); sbyte(8'h05, ad);
    i_start; sbyte({A0, 1'b1}, aa); gbyte(v, 1'b1);
    chk(v == rd_exp(intn0, cfg0), "R3 read before stop", v, rd_exp(intn0, cfg0));
    chk(en0 == sw_en(cfg0), "R3 repeated start keeps", en0, sw_en(cfg0));
    i_stop; wq(12); cfg0 = 8'h05;
    chk(en0 == sw_en(cfg0), "R3 applied at stop", en0, sw_en(cfg0));

    // R7/R8: interrupts live in read byte and on output
    intn0 = 4'b1010; wq(8);
    chk(irq0 == 1'b1, "R7 irq asserted", irq0, 1);
    i_start; sbyte({A0, 1'b1}, aa); gbyte(v, 1'b0); gbyte(v2, 1'b1); i_stop;
    chk(v == rd_exp(intn0, cfg0), "R8 read with interrupts", v, rd_exp(intn0, cfg0));
    chk(v2 == v, "R8 repeated read byte", v2, v);
    chk(!oe0, "R8 release after nack", oe0, 0);
    intn0 = 4'hF; wq(8);
    chk(irq0 == 1'b0, "R7 not latched", irq0, 0);
    rd_dev(A0, aa, v);
    chk(v == rd_exp(intn0, cfg0), "R8 interrupt bits cleared", v, rd_exp(intn0, cfg0));

    // R5: multiplexer device
    wr_dev(A1, 8'h06, aa, ad); wq(12); cfg1 = 8'h06 & 8'h07;
    chk(en1 == mx_en(cfg1), "R5 mux select 2", en1, mx_en(cfg1));
    wr_dev(A1, 8'hF3, aa, ad); wq(12); cfg1 = 8'hF3 & 8'h07;
    chk(en1 == 4'h0, "R5 mux disabled", en1, 0);
    wr_dev(A1, 8'hFF, aa, ad); wq(12); cfg1 = 8'hFF & 8'h07;
    chk(en1 == 4'b1000, "R5 mux select 3", en1, 4'b1000);
    intn1 = 4'b0110; wq(8);
    rd_dev(A1, aa, v);
    chk(v == rd_exp(intn1, cfg1), "R8 mux read format", v, rd_exp(intn1, cfg1));
    chk(en0 == sw_en(cfg0), "R1 other device untouched", en0, sw_en(cfg0));
    intn1 = 4'hF;

    // random control bytes against both devices
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      logic dv;
      d = 8'($urandom);
      dv = 1'($urandom);
      if (dv) begin
        wr_dev(A1, d, aa, ad); wq(12); cfg1 = d & 8'h07;
        chk(en1 == mx_en(cfg1), "R5 random mux", en1, mx_en(cfg1));
        intn1 = 4'($urandom); wq(8);
        rd_dev(A1, aa, v);
        chk(v == rd_exp(intn1, cfg1), "R8 random mux read", v, rd_exp(intn1, cfg1));
      end else begin
        wr_dev(A0, d, aa, ad); wq(12); cfg0 = d & 8'h0F;
        chk(en0 == sw_en(cfg0), "R4 random switch", en0, sw_en(cfg0));
        intn0 = 4'($urandom); wq(8);
        rd_dev(A0, aa, v);
        chk(v == rd_exp(intn0, cfg0), "R8 random switch read", v, rd_exp(intn0, cfg0));
      end
      chk(irq0 == (intn0 != 4'hF) && irq1 == (intn1 != 4'hF), "R7 random irq",
          {irq0, irq1}, {intn0 != 4'hF, intn1 != 4'hF});
    end

    // R6: reset mid-write drops pending value
    i_start; sbyte({A0, 1'b0}, aa); sbyte(8'h0F, ad);
    @(negedge clk) rst = 1'b1; wq(4); rst = 1'b0;
    i_stop; wq(12);
    chk(en0 == 4'h0 && en1 == 4'h0, "R6 reset clears", {en0, en1}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule